// File: doc/BRIEF.md
# Byte-Addressed GPIO Port with Read Inversion

This block drives and senses twelve general-purpose pins. Each pin has four control bits: a direction bit, an output value bit, a drive-type bit and a read-inversion bit. The control bits are packed eight to a byte and reached over a narrow internal register bus, which carries an address, a write strobe, write data and combinational read data. The current pin levels are read back through two read-only bytes. Each reported bit is the pin's real level XOR its inversion bit, so firmware can choose the polarity of every input. A pin that is being driven therefore reads back its driven level passed through the same XOR.

A one-cycle load pulse copies a packed default image from a configuration input bus into every control flip-flop. This stands in for the power-up or refresh copy out of nonvolatile storage. The load wins over a bus write in the same cycle. Outside the chip, the pin pads combine the output, enable and input signals. Released open-drain pins are expected to have a pull-up.

Top module: `gpio_xor_port`

## Requirements
- R1: After reset every control bit is 0, every pin has its output enable low, and addresses 0 to 7 read 0.
- R2: The control map is direction at addresses 0/1, inversion at 2/3, drive type at 4/5 and output value at 6/7. The even address holds pins 0 to 7 in bits 0 to 7. The odd address holds pins 8 to 11 in bits 0 to 3. A written value reads back from the next cycle on.
- R3: Bits 7 to 4 of the odd control bytes always read 0, and writing them has no effect. This holds both for bus writes and for the load.
- R4: Address 8 returns the levels of pins 0 to 7 XOR inversion bits 0 to 7. Address 9 returns the levels of pins 8 to 11 XOR their inversion bits in bits 3 to 0, with bits 7 to 4 always 0.
- R5: The input bytes show the level of the pin and not the output value register. This holds whatever the direction: an output pin that is externally held low reads low before inversion.
- R6: A pin whose direction bit is 0 (input) has its output enable low.
- R7: A pin with direction 1 and drive type 1 (push-pull) has its output enable high and drives its output value.
- R8: A pin with direction 1 and drive type 0 (open-drain) drives 0 when its output value is 0 and releases its output enable when its output value is 1.
- R9: Writes to addresses 8 to 15 change no control bit. Addresses 10 to 15 read 0.
- R10: A load pulse copies byte k of the configuration image (bits 8k+7 to 8k) into the control byte at address k, for k = 0 to 7, within one clock.
- R11: When a load and a bus write fall in the same cycle, the load's value is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load the configuration image into all control bits |
| cfg_image | input | 64 | Packed default image, byte k for address k |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 12 | Sensed pin levels |
| pin_out | output | 12 | Pin output data |
| pin_oe | output | 12 | Pin output enables |

## Verification
The input bytes are read with every pin set as input, with every pin driven push-pull, and with every pin driven open-drain. In the open-drain case one released pin is held low from outside, which shows that the reported value comes from the pin and not from the output register. Each of these patterns is read under an inversion mask that is neither all zeros nor all ones, so a missing XOR or one applied to the wrong bit position shows up. Loading an image that has bits set in the unused upper nibbles checks that those bits are masked. Writing through the bus in the load cycle checks which of the two wins.

// File: rtl/gpio_xor_port.sv
module gpio_xor_port #(
  parameter int NPINS = 12,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [63:0]      cfg_image,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);
  localparam int NREG = 8;
  localparam int HIW  = NPINS - 8;
  localparam logic [7:0] HIMASK = 8'((1 << HIW) - 1);
  localparam logic [AW-1:0] IN_LO = AW'(NREG);
  localparam logic [AW-1:0] IN_HI = AW'(NREG + 1);

  logic [7:0] ctl_q [NREG];
  logic [NPINS-1:0] dir_q, inv_q, typ_q, val_q, in_val;

  function automatic logic [7:0] byte_mask(input logic [2:0] idx);
    return idx[0] ? HIMASK : 8'hFF;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) ctl_q[k] <= '0;
    end else if (cfg_load) begin
      for (int k = 0; k < NREG; k++) ctl_q[k] <= cfg_image[8*k +: 8] & byte_mask(3'(k));
    end else if (bus_we && bus_addr < IN_LO) begin
      ctl_q[bus_addr[2:0]] <= bus_wdata & byte_mask(bus_addr[2:0]);
    end
  end

  assign dir_q  = {ctl_q[1][HIW-1:0], ctl_q[0]};
  assign inv_q  = {ctl_q[3][HIW-1:0], ctl_q[2]};
  assign typ_q  = {ctl_q[5][HIW-1:0], ctl_q[4]};
  assign val_q  = {ctl_q[7][HIW-1:0], ctl_q[6]};

  assign in_val  = pin_in ^ inv_q;
  assign pin_oe  = dir_q & (typ_q | ~val_q);
  assign pin_out = val_q & typ_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr < IN_LO)       bus_rdata = ctl_q[bus_addr[2:0]];
    else if (bus_addr == IN_LO) bus_rdata = in_val[7:0];
    else if (bus_addr == IN_HI) bus_rdata = 8'(in_val[NPINS-1:8]);
  end
endmodule

module gpio_xor_port_chk #(
  parameter int NPINS = 12,
  parameter int AW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_load,
  input logic [63:0]      cfg_image,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_we,
  input logic [7:0]       bus_rdata,
  input logic [NPINS-1:0] pin_in,
  input logic [NPINS-1:0] pin_oe,
  input logic [NPINS-1:0] dir_q,
  input logic [NPINS-1:0] inv_q,
  input logic [NPINS-1:0] typ_q,
  input logic [NPINS-1:0] val_q
);
  localparam int HIW = NPINS - 8;
  logic [NPINS-1:0] img_dir, img_inv, img_typ, img_val;
  assign img_dir = {cfg_image[8  +: HIW], cfg_image[0  +: 8]};
  assign img_inv = {cfg_image[24 +: HIW], cfg_image[16 +: 8]};
  assign img_typ = {cfg_image[40 +: HIW], cfg_image[32 +: 8]};
  assign img_val = {cfg_image[56 +: HIW], cfg_image[48 +: 8]};

  // R10
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (dir_q == $past(img_dir)) && (inv_q == $past(img_inv)) &&
                 (typ_q == $past(img_typ)) && (val_q == $past(img_val)));

  // R11
  load_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && bus_we && bus_addr == '0) |=> dir_q == $past(img_dir));

  // R6
  input_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~dir_q) == '0);

  // R4
  hi_nibble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(9)) |-> (bus_rdata >> HIW) == '0);

  // R4
  in_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(8)) |-> bus_rdata == (pin_in[7:0] ^ inv_q[7:0]));

  // R9
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !cfg_load && bus_addr >= AW'(8)) |=>
      $stable(dir_q) && $stable(inv_q) && $stable(typ_q) && $stable(val_q));
endmodule

bind gpio_xor_port gpio_xor_port_chk #(.NPINS(NPINS), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_image(cfg_image),
  .bus_addr(bus_addr), .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
  .pin_oe(pin_oe), .dir_q(dir_q), .inv_q(inv_q), .typ_q(typ_q), .val_q(val_q)
);

// File: tb/gpio_xor_port_tb_top.sv
module gpio_xor_port_tb_top;
  localparam int NP = 12;
  logic clk = 0, rst_n = 0, cfg_load = 0, bus_we = 0;
  logic [63:0] cfg_image = '0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic [NP-1:0] pin_in, pin_out, pin_oe, ext = '1;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_xor_port dut_i (.clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_image(cfg_image),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  typedef struct { int kind; logic [15:0] exp; string tag; } item_t;
  item_t sq[$];
  logic [7:0] m [8];

  function automatic logic [7:0] msk(int a); return a[0] ? 8'h0F : 8'hFF; endfunction
  function automatic logic [NP-1:0] fld(int a); return {m[a+1][3:0], m[a]}; endfunction
  function automatic logic [NP-1:0] exp_oe();
    return fld(0) & (fld(4) | ~fld(6));
  endfunction
  function automatic logic [NP-1:0] exp_pin();
    logic [NP-1:0] oe = exp_oe();
    logic [NP-1:0] dv = fld(6) & fld(4);
    return (oe & dv) | (~oe & ext);
  endfunction
  function automatic logic [7:0] exp_rd(int a);
    logic [NP-1:0] iv = exp_pin() ^ fld(2);
    if (a < 8) return m[a];
    if (a == 8) return iv[7:0];
    if (a == 9) return {4'h0, iv[11:8]};
    return 8'h00;
  endfunction

  initial forever begin
    item_t it;
    logic [15:0] act;
    wait (sq.size() > 0);
    it = sq.pop_front();
    #1;
    act = (it.kind == 0) ? {8'h00, bus_rdata} : (it.kind == 1) ? {4'h0, pin_oe} : {4'h0, pin_out};
    nchk++;
    if (act !== it.exp) begin
      nerr++;
      $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
    end
  end

  task automatic push(int kind, logic [15:0] e, string tag);
    item_t it; it.kind = kind; it.exp = e; it.tag = tag;
    sq.push_back(it);
    #3;
  endtask
  task automatic rd(int a, string tag);
    @(negedge clk); bus_addr = 4'(a); push(0, {8'h00, exp_rd(a)}, tag);
  endtask
  task automatic chk_pins(string tag);
    logic [NP-1:0] oe = exp_oe();
    @(negedge clk); push(1, {4'h0, oe}, tag);
    @(negedge clk); push(2, {4'h0, fld(6) & fld(4)}, tag);
  endtask
  task automatic wr(int a, logic [7:0] d);
    @(negedge clk); bus_addr = 4'(a); bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
    if (a < 8) m[a] = d & msk(a);
  endtask
  task automatic load(logic [63:0] img, bit with_wr);
    @(negedge clk); cfg_image = img; cfg_load = 1;
    if (with_wr) begin bus_addr = 0; bus_wdata = 8'h3C; bus_we = 1; end
    @(negedge clk); cfg_load = 0; bus_we = 0;
    for (int k = 0; k < 8; k++) m[k] = img[8*k +: 8] & msk(k);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) m[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 8; a++) rd(a, "R1");
    chk_pins("R1");
    // R2 R3 map and packing
    wr(0, 8'hA5); wr(1, 8'hFF); wr(2, 8'h3C); wr(3, 8'hFA);
    wr(4, 8'h81); wr(5, 8'h76); wr(6, 8'h5E); wr(7, 8'hC9);
    for (int a = 0; a < 8; a++) rd(a, (a % 2) ? "R3" : "R2");
    // R6 R4 R5 all inputs
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'hF0); wr(3, 8'h05);
    ext = 12'h5A3;
    chk_pins("R6");
    rd(8, "R4"); rd(9, "R4");
    ext = 12'hC3C;
    rd(8, "R5"); rd(9, "R5");
    // R7 push-pull outputs
    wr(0, 8'hFF); wr(1, 8'h0F); wr(4, 8'hFF); wr(5, 8'h0F); wr(6, 8'hC6); wr(7, 8'h09);
    chk_pins("R7");
    rd(8, "R7"); rd(9, "R7");
    // R8 open-drain with pull-up
    wr(4, 8'h00); wr(5, 8'h00);
    ext = 12'hFFF;
    chk_pins("R8");
    rd(8, "R8"); rd(9, "R8");
    // R5 released open-drain pin held low externally
    ext = 12'hFFD;
    rd(8, "R5");
    // R9 read-only and unmapped addresses
    wr(8, 8'hFF); wr(9, 8'hFF); wr(12, 8'h55);
    for (int a = 0; a < 8; a++) rd(a, "R9");
    rd(12, "R9"); rd(15, "R9");
    // R10 load image, upper nibbles set
    load(64'hF3_5A_E7_81_F0_0F_FC_33, 0);
    for (int a = 0; a < 10; a++) rd(a, "R10");
    chk_pins("R10");
    // R11 load beats write
    load(64'h12_34_56_78_9A_BC_DE_F0, 1);
    rd(0, "R11"); rd(1, "R11");
    repeat (2) @(negedge clk);
    wait (sq.size() == 0);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule